// File: doc/BRIEF.md
# I2C Master Bit-Clock Divider with Line Deglitching

This block sets the SCL rhythm for a byte-oriented I2C master. A 3-bit rate code selects one of seven fixed divisions of the system clock. The eighth code instead takes its pace from an external timer overflow strobe. The block toggles a released-high SCL level once per half bit period and marks each toggle with a one-cycle pulse. The shift and sequencing logic of the master uses that pulse to move data.

Alongside the divider, two independent deglitchers clean the SCL and SDA levels sampled from the bus. A level change is passed on only after it has stayed put for three consecutive clock samples. Shorter spikes never reach the protocol logic. Deglitching runs whether or not the divider is enabled.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, scl_out = 1, half_tick = 0, scl_filt = 1 and sda_filt = 1.
- R2: With en = 1 and rate_sel below 7, each SCL half period lasts D/2 clock cycles. D is 256, 224, 192, 160, 960, 120 or 60 for codes 0, 1, 2, 3, 4, 5 and 6. The first toggle is from 1 to 0, D/2 cycles after the first enabled clock edge.
- R3: half_tick is high for exactly the one cycle in which scl_out takes a new value. It is low in every other cycle.
- R4: With rate_sel = 7, scl_out toggles on every fourth clock edge that samples tmr_ovf high, so one bit period takes eight strobes. If strobes arrive every 12*(256-reload) cycles, the bit period is 96*(256-reload) cycles. With no strobes, scl_out holds its level.
- R5: For rate codes 0 to 6, tmr_ovf has no effect on scl_out or half_tick.
- R6: The first clock edge with en = 0 drives scl_out to 1 and half_tick to 0 and clears all divide state. After re-enabling, timing restarts as described in R2.
- R7: While enabled, a change of rate_sel restarts the half-period count and leaves scl_out at its level. The next toggle comes one full new half period after the first edge that sees the new code, which is D/2+1 cycles after the code changes.
- R8: scl_filt follows scl_in, and sda_filt follows sda_in, only after the input has differed from the output on 3 consecutive clock edges. The output changes on the third such edge. Pulses of 1 or 2 cycles are dropped.
- R9: In the fixed-rate modes, no SCL half period is shorter than 16 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider enable; low releases SCL and clears the count |
| rate_sel | input | 3 | Rate code (0 to 6 fixed divisors, 7 timer-strobe mode) |
| tmr_ovf | input | 1 | One-cycle timer overflow strobe, used in code 7 |
| scl_in | input | 1 | SCL level sampled from the bus |
| sda_in | input | 1 | SDA level sampled from the bus |
| scl_out | output | 1 | Generated SCL level (1 = released, 0 = pull low) |
| half_tick | output | 1 | Pulse marking each SCL half-period boundary |
| scl_filt | output | 1 | Deglitched SCL |
| sda_filt | output | 1 | Deglitched SCL companion: deglitched SDA |

## Verification
The bench measures every half period of all seven fixed codes against the divisor table while toggling tmr_ovf. A swapped table entry, or a divider that listened to the strobe, would show up as a wrong length. In code 7 it counts strobes and cycle gaps, so counting the wrong number of strobes per half would be caught. It changes the rate code mid-phase and expects D/2+1 cycles to the next toggle. A design that kept the old count would toggle early. It disables mid-phase and expects SCL released one cycle later. Deglitcher pulses of 1, 2, 3 and 5 cycles on both lines separate a filter that is one sample too short or too long.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
  localparam int HALF_W = 9;
  localparam logic [2:0] RATE_TIMER = 3'b111;

  // half of the oscillator divisor for each fixed rate code
  function automatic logic [HALF_W-1:0] half_div(input logic [2:0] code);
    logic [HALF_W-1:0] h;
    case (code)
      3'd0:    h = HALF_W'(128);
      3'd1:    h = HALF_W'(112);
      3'd2:    h = HALF_W'(96);
      3'd3:    h = HALF_W'(80);
      3'd4:    h = HALF_W'(480);
      3'd5:    h = HALF_W'(60);
      3'd6:    h = HALF_W'(30);
      default: h = HALF_W'(128);
    endcase
    return h;
  endfunction
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int   FILT_CLKS = 3,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_CLKS + 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= RST_LEVEL;
      run  <= '0;
    end else if (raw == filt) begin
      run <= '0;
    end else if (run == CW'(FILT_CLKS - 1)) begin
      filt <= raw;
      run  <= '0;
    end else begin
      run <= run + CW'(1);
    end
  end

  generate
    if (FILT_CLKS == 3) begin : g_chk3
      // R8: a new output level must have been seen on the last three samples
      p_hold_three_r8: assert property (@(posedge clk) disable iff (rst)
        (filt != $past(filt)) |->
          ($past(raw) == filt && $past(raw, 2) == filt && $past(raw, 3) == filt));
    end
  endgenerate
endmodule

// File: rtl/i2c_fixed_half_div.sv
module i2c_fixed_half_div #(
  parameter int HALF_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              active,
  input  logic [HALF_W-1:0] half_len,
  output logic              done
);
  logic [HALF_W-1:0] cnt;

  assign done = active && (cnt == (half_len - HALF_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (active) begin
      cnt <= done ? '0 : cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/i2c_ovf_half_div.sv
module i2c_ovf_half_div #(
  parameter int TICKS_PER_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic active,
  input  logic ovf,
  output logic done
);
  localparam int TW = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1;

  logic [TW-1:0] tcnt;

  assign done = active && ovf && (tcnt == TW'(TICKS_PER_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tcnt <= '0;
    end else if (active && ovf) begin
      tcnt <= done ? '0 : tcnt + TW'(1);
    end
  end
endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen #(
  parameter int HALF_W         = i2c_rate_pkg::HALF_W,
  parameter int TICKS_PER_HALF = 4,
  parameter int FILT_CLKS      = 3,
  parameter int MIN_HALF_CLKS  = 16,
  parameter int RUN_W          = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] rate_sel,
  input  logic       tmr_ovf,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_out,
  output logic       half_tick,
  output logic       scl_filt,
  output logic       sda_filt
);
  localparam int N_LINES = 2;

  logic [2:0]        sel_q;
  logic              mode_timer;
  logic              restart;
  logic [HALF_W-1:0] half_len;
  logic              fixed_done;
  logic              ovf_done;
  logic              toggle;
  logic [RUN_W-1:0]  run_len;

  assign mode_timer = (rate_sel == i2c_rate_pkg::RATE_TIMER);
  assign restart    = !en || (rate_sel != sel_q);
  assign half_len   = HALF_W'(i2c_rate_pkg::half_div(rate_sel));
  assign toggle     = !restart && (fixed_done || ovf_done);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= rate_sel;
  end

  i2c_fixed_half_div #(.HALF_W(HALF_W)) fixed_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (restart),
    .active   (en && !mode_timer),
    .half_len (half_len),
    .done     (fixed_done)
  );

  i2c_ovf_half_div #(.TICKS_PER_HALF(TICKS_PER_HALF)) ovf_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (restart),
    .active (en && mode_timer),
    .ovf    (tmr_ovf),
    .done   (ovf_done)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      scl_out   <= 1'b1;
      half_tick <= 1'b0;
    end else begin
      half_tick <= toggle;
      if (toggle) scl_out <= ~scl_out;
    end
  end

  // cycles since the last half boundary or restart, used only for checking
  always_ff @(posedge clk) begin
    if (rst || restart || toggle) run_len <= '0;
    else if (run_len != '1)       run_len <= run_len + RUN_W'(1);
  end

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;
  assign raw_lines = {sda_in, scl_in};

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_filt
      i2c_glitch_filter #(.FILT_CLKS(FILT_CLKS), .RST_LEVEL(1'b1)) filt_i (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw_lines[g]),
        .filt (clean_lines[g])
      );
    end
  endgenerate

  assign scl_filt = clean_lines[0];
  assign sda_filt = clean_lines[1];

  // R6: disabling releases SCL on the next edge
  p_release_off_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_out && !half_tick));

  // R3: the boundary marker never lasts two cycles
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> !half_tick);

  // R4: in timer mode a boundary needs a sampled overflow strobe
  p_timer_needs_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (half_tick && $past(mode_timer)) |-> $past(tmr_ovf));

  // R9: fixed-rate half periods respect the minimum length
  p_min_half_r9: assert property (@(posedge clk) disable iff (rst)
    (fixed_done && !restart) |-> (run_len >= RUN_W'(MIN_HALF_CLKS - 1)));
endmodule

// File: tb/i2c_scl_rate_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst, en, tmr_ovf, scl_in, sda_in;
  logic [2:0] rate_sel;
  logic       scl_out, half_tick, scl_filt, sda_filt;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc++;

  i2c_scl_rate_gen dut_i (
    .clk(clk), .rst(rst), .en(en), .rate_sel(rate_sel), .tmr_ovf(tmr_ovf),
    .scl_in(scl_in), .sda_in(sda_in), .scl_out(scl_out), .half_tick(half_tick),
    .scl_filt(scl_filt), .sda_filt(sda_filt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int half_of(input int code);
    case (code)
      0: return 128; 1: return 112; 2: return 96; 3: return 80;
      4: return 480; 5: return 60; default: return 30;
    endcase
  endfunction

  // R2 R3 R5 R6: measure four halves of a fixed code with tmr_ovf toggling
  task automatic run_fixed(input int code);
    int h, cnt, stray;
    logic prev;
    h = half_of(code);
    en = 1'b0; rate_sel = 3'(code); tick(3);
    chk(scl_out == 1'b1, "R6 released while off", int'(scl_out), 1);
    en = 1'b1; prev = 1'b1; stray = 0;
    for (int k = 0; k < 4; k++) begin
      cnt = 0;
      do begin
        tick(1);
        tmr_ovf = ~tmr_ovf;
        cnt++;
        if (scl_out == prev && half_tick) stray++;
      end while (scl_out == prev && cnt < 2 * h + 4);
      chk(cnt == h, $sformatf("R2 R5 code %0d half %0d", code, k), cnt, h);
      chk(half_tick == 1'b1, "R3 marker at boundary", int'(half_tick), 1);
      if (k == 0) chk(scl_out == 1'b0, "R2 first toggle falls", int'(scl_out), 0);
      prev = scl_out;
    end
    chk(stray == 0, "R3 no marker between boundaries", stray, 0);
    tmr_ovf = 1'b0;
  endtask

  // R4: strobes every p cycles, toggle on each fourth
  task automatic run_timer(input int p, input int n);
    int last_t, bad;
    logic exp_scl;
    en = 1'b0; rate_sel = 3'd7; tick(3);
    en = 1'b1; tick(2);
    last_t = -1; bad = 0;
    for (int k = 1; k <= n; k++) begin
      tick(p - 1);
      tmr_ovf = 1'b1;
      tick(1);
      tmr_ovf = 1'b0;
      exp_scl = ((k / 4) % 2 == 1) ? 1'b0 : 1'b1;
      if (scl_out != exp_scl) bad++;
      if (half_tick != (k % 4 == 0)) bad++;
      if (k % 4 == 0) begin
        if (last_t >= 0)
          chk(cyc - last_t == 4 * p, $sformatf("R4 half length p=%0d", p), cyc - last_t, 4 * p);
        last_t = cyc;
      end
    end
    chk(bad == 0, $sformatf("R4 level per strobe p=%0d", p), bad, 0);
  endtask

  function automatic logic filt_of(input int line);
    return (line == 0) ? scl_filt : sda_filt;
  endfunction

  task automatic set_line(input int line, input logic v);
    if (line == 0) scl_in = v; else sda_in = v;
  endtask

  // R8: low pulse of width w on one line
  task automatic filt_pulse(input int line, input int w);
    int bad;
    logic e;
    bad = 0;
    set_line(line, 1'b0);
    for (int j = 1; j <= w; j++) begin
      tick(1);
      e = (w >= 3 && j >= 3) ? 1'b0 : 1'b1;
      if (filt_of(line) != e) bad++;
    end
    set_line(line, 1'b1);
    for (int j = 1; j <= 5; j++) begin
      tick(1);
      e = (w >= 3 && j < 3) ? 1'b0 : 1'b1;
      if (filt_of(line) != e) bad++;
    end
    chk(bad == 0, $sformatf("R8 line %0d width %0d", line, w), bad, 0);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    rst = 1'b1; en = 1'b0; rate_sel = 3'd0; tmr_ovf = 1'b0;
    scl_in = 1'b1; sda_in = 1'b1;
    tick(3);
    chk(scl_out == 1'b1 && half_tick == 1'b0, "R1 divider reset", int'({scl_out, half_tick}), 2);
    chk(scl_filt == 1'b1 && sda_filt == 1'b1, "R1 filter reset", int'({scl_filt, sda_filt}), 3);
    rst = 1'b0;
    tick(1);
    chk(scl_out == 1'b1 && half_tick == 1'b0, "R1 after release", int'({scl_out, half_tick}), 2);

    for (int c = 0; c < 7; c++) run_fixed(c);

    // R6 disable mid low phase, stays released
    en = 1'b0; rate_sel = 3'd6; tick(3); en = 1'b1; tick(40);
    chk(scl_out == 1'b0, "R6 setup low phase", int'(scl_out), 0);
    en = 1'b0; tick(1);
    chk(scl_out == 1'b1 && half_tick == 1'b0, "R6 release next edge", int'(scl_out), 1);
    tick(50);
    chk(scl_out == 1'b1, "R6 stays released", int'(scl_out), 1);

    // R7 rate change restarts count, keeps level
    en = 1'b1; cnt = 0;
    while (scl_out == 1'b1 && cnt < 100) begin tick(1); cnt++; end
    tick(10);
    rate_sel = 3'd5; cnt = 0;
    do begin tick(1); cnt++; end while (scl_out == 1'b0 && cnt < 200);
    chk(cnt == 61, "R7 restart after code change", cnt, 61);

    run_timer(2, 12);
    run_timer(5, 12);
    run_timer(24, 12);   // reload 254: bit period 192
    // R4 no strobes, no movement
    tick(1);
    begin
      logic held;
      held = scl_out; cnt = 0;
      repeat (200) begin tick(1); if (scl_out != held || half_tick) cnt++; end
      chk(cnt == 0, "R4 hold without strobes", cnt, 0);
    end

    for (int ln = 0; ln < 2; ln++) begin
      filt_pulse(ln, 1);
      filt_pulse(ln, 2);
      filt_pulse(ln, 3);
      filt_pulse(ln, 5);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule